// File: doc/BRIEF.md
# Threshold Edge Event Counter

This block holds a pair of 40-bit event counters. Each counter is steered by a 32-bit function word. Every clock cycle an array of event slots reports how often each event happened in that cycle, as a 4-bit occurrence count, together with a 5-bit attribute field. A privilege input says whether the current cycle belongs to kernel or user execution. The function word picks one slot, filters it through a unit mask, and then either adds the raw count or compares it against a programmable threshold. That comparison can be inverted and can be reduced to rising edges. Counter 0's function word also carries a master enable that gates both counters.

Software programs the function words through a one-cycle write port. Writes that place an event code on a counter that may not carry it are refused. A read port returns any counter's live value while counting carries on. Each counter has a two-state edge-history machine. HIST_IDLE means the qualified condition was inactive in the previous cycle and HIST_SEEN means it was active. The transitions are: IDLE to SEEN when the condition is active, SEEN to IDLE when it is inactive, and any state to IDLE on a write to that counter's function.

Top module: `evt_thresh_counter`

## Requirements
- R1: After reset, both counters read 0, `wr_err` is 0 and both function words are 0, so nothing counts.
- R2: The function word is laid out as threshold in bits 31:24, flags in 23:16, unit mask in 15:8 and event code in 7:0. The event slot used is the code modulo 16; slot k occupies `evt_occ[4k+3:4k]`. With a zero threshold, the counter adds the qualified occurrence count of its slot every enabled cycle.
- R3: With a nonzero threshold and flag bit 23 clear, the counter adds 1 in each enabled cycle whose qualified count is greater than or equal to the threshold, and adds 0 otherwise.
- R4: With a nonzero threshold and flag bit 23 (invert) set, the counter adds 1 in each enabled cycle whose qualified count is less than or equal to the threshold.
- R5: With flag bit 18 (edge) set, the counter adds 1 only in a cycle where the condition is active and was not active in the previous cycle. With a zero threshold, the condition is a nonzero qualified count.
- R6: Bit 22 of counter 0's function enables both counters; when it is clear, neither counter changes. Bit 22 of counter 1's function has no effect.
- R7: When `priv_kernel`=1 a counter counts only if its bit 17 is set; when `priv_kernel`=0 it counts only if its bit 16 is set.
- R8: The slot's attribute field is `evt_attr[5k+4:5k]`. Its bits 3:0 are the line states modified, exclusive, shared and invalid, and bit 4 marks a transaction from another agent. An occurrence count contributes only if unit-mask bits 3:0 are zero or share a set bit with the attribute's bits 3:0. In addition, attribute bit 4 must be clear or unit-mask bit 4 must be set. Otherwise the count is treated as 0.
- R9: Counter 0 refuses event codes 0x11, 0x12 and 0x13; counter 1 refuses 0x10, 0x14 and 0xc1. A refused write keeps the old function and sets `wr_err` from the next cycle. An accepted write clears `wr_err`.
- R10: A function write takes effect from the following cycle. The cycle of the write itself counts under the old function. An accepted write resets that counter's edge history, so a condition that is active just after the write counts as a new edge.
- R11: `rd_data` shows the counter selected by `rd_sel` in the same cycle, without disturbing counting, and counters wrap modulo 2^40.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| priv_kernel | input | 1 | 1 for a kernel-mode cycle, 0 for user mode |
| evt_occ | input | 64 | Per-slot occurrence counts, 16 slots of 4 bits |
| evt_attr | input | 80 | Per-slot attributes, 16 slots of 5 bits |
| wr_en | input | 1 | Function write strobe |
| wr_sel | input | 1 | Counter addressed by the write |
| wr_data | input | 32 | Function word to write |
| rd_sel | input | 1 | Counter shown on rd_data |
| rd_data | output | 40 | Value of the selected counter |
| wr_err | output | 1 | Last function write was refused |

## Verification
A function write and a count can land on the same clock edge. The count at that edge must still follow the old function, while the edge history is forced back to idle. The bench provokes this in its random phase by mixing writes with live event traffic. It also uses directed writes while an edge-mode condition stays high. Each case is judged by a behavioural model that applies the count of a cycle with the pre-write function and only then installs the new word. The model's counters and error flag are compared with the read port on every cycle.

// File: rtl/etc_pkg.sv
package etc_pkg;

    localparam int FN_W   = 32;
    localparam int ATTR_W = 5;

    typedef struct packed {
        logic [7:0] thresh;
        logic       inv;
        logic       glob_en;
        logic [2:0] spare;
        logic       edg;
        logic       kern;
        logic       user;
        logic [7:0] umask;
        logic [7:0] code;
    } func_t;

    typedef enum logic {
        HIST_IDLE = 1'b0,
        HIST_SEEN = 1'b1
    } hist_t;

    function automatic logic code_allowed(input int unsigned sel, input logic [7:0] code);
        logic ok;
        unique case (code)
            8'h10, 8'h14, 8'hc1: ok = (sel == 0);
            8'h11, 8'h12, 8'h13: ok = (sel == 1);
            default:             ok = 1'b1;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/etc_qualify.sv
module etc_qualify
    import etc_pkg::*;
#(
    parameter int OCC_W = 4
) (
    input  func_t              fn,
    input  logic [OCC_W-1:0]   occ,
    input  logic [ATTR_W-1:0]  attr,
    input  logic               priv_kernel,
    input  logic               glob_en,
    output logic               active,
    output logic [OCC_W-1:0]   level_add
);
    localparam int CMP_W = (OCC_W > 8) ? OCC_W : 8;

    logic             state_hit;
    logic             agent_ok;
    logic [OCC_W-1:0] q_occ;
    logic [CMP_W-1:0] q_ext;
    logic [CMP_W-1:0] th_ext;
    logic             mode_ok;
    logic             cond;

    always_comb begin
        state_hit = (fn.umask[3:0] == 4'd0) || ((fn.umask[3:0] & attr[3:0]) != 4'd0);
        agent_ok  = !attr[4] || fn.umask[4];
        q_occ     = (state_hit && agent_ok) ? occ : '0;
        q_ext     = CMP_W'(q_occ);
        th_ext    = CMP_W'(fn.thresh);
        mode_ok   = glob_en && (priv_kernel ? fn.kern : fn.user);
        if (fn.thresh == 8'd0) begin
            cond      = (q_occ != '0);
            level_add = mode_ok ? q_occ : '0;
        end else begin
            cond      = fn.inv ? (q_ext <= th_ext) : (q_ext >= th_ext);
            level_add = (mode_ok && cond) ? OCC_W'(1) : '0;
        end
        active = mode_ok && cond;
    end

endmodule

// File: rtl/etc_lane.sv
module etc_lane
    import etc_pkg::*;
#(
    parameter int CTR_W   = 40,
    parameter int OCC_W   = 4,
    parameter int NUM_EVT = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      priv_kernel,
    input  logic                      glob_en,
    input  logic [NUM_EVT*OCC_W-1:0]  evt_occ,
    input  logic [NUM_EVT*ATTR_W-1:0] evt_attr,
    input  logic                      fn_we,
    input  func_t                     fn_wdata,
    output func_t                     fn_q,
    output logic [CTR_W-1:0]          value
);
    localparam int IDX_W = $clog2(NUM_EVT);

    hist_t             hist_q, hist_d;
    logic [IDX_W-1:0]  slot;
    logic [OCC_W-1:0]  occ_sel;
    logic [ATTR_W-1:0] attr_sel;
    logic              active;
    logic [OCC_W-1:0]  level_add;
    logic [OCC_W-1:0]  inc;

    assign slot     = fn_q.code[IDX_W-1:0];
    assign occ_sel  = evt_occ[slot*OCC_W +: OCC_W];
    assign attr_sel = evt_attr[slot*ATTR_W +: ATTR_W];

    etc_qualify #(.OCC_W(OCC_W)) u_qual (
        .fn          (fn_q),
        .occ         (occ_sel),
        .attr        (attr_sel),
        .priv_kernel (priv_kernel),
        .glob_en     (glob_en),
        .active      (active),
        .level_add   (level_add)
    );

    // edge-history state register
    always_ff @(posedge clk) begin
        if (!rst_n) hist_q <= HIST_IDLE;
        else        hist_q <= hist_d;
    end

    // next state and increment
    always_comb begin
        hist_d = hist_q;
        inc    = '0;
        unique case (hist_q)
            HIST_IDLE: begin
                if (active) hist_d = HIST_SEEN;
                inc = fn_q.edg ? (active ? OCC_W'(1) : '0) : level_add;
            end
            HIST_SEEN: begin
                if (!active) hist_d = HIST_IDLE;
                inc = fn_q.edg ? '0 : level_add;
            end
        endcase
        if (fn_we) hist_d = HIST_IDLE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fn_q  <= '0;
            value <= '0;
        end else begin
            value <= value + CTR_W'(inc);
            if (fn_we) fn_q <= fn_wdata;
        end
    end

    a_r6_master_off: assert property (@(posedge clk) disable iff (!rst_n)
        !glob_en |=> (value == $past(value)));
    a_r7_no_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (!fn_q.user && !fn_q.kern) |=> (value == $past(value)));
    a_r5_edge_single: assert property (@(posedge clk) disable iff (!rst_n)
        fn_q.edg |=> ((value - $past(value)) <= CTR_W'(1)));
    a_r3_thresh_single: assert property (@(posedge clk) disable iff (!rst_n)
        (fn_q.thresh != 8'd0) |=> ((value - $past(value)) <= CTR_W'(1)));
    a_r2_raw_bound: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((value - $past(value)) < CTR_W'(1 << OCC_W)));

endmodule

// File: rtl/evt_thresh_counter.sv
module evt_thresh_counter
    import etc_pkg::*;
#(
    parameter int NUM_CTR = 2,
    parameter int CTR_W   = 40,
    parameter int OCC_W   = 4,
    parameter int NUM_EVT = 16,
    localparam int SEL_W  = (NUM_CTR > 1) ? $clog2(NUM_CTR) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      priv_kernel,
    input  logic [NUM_EVT*OCC_W-1:0]  evt_occ,
    input  logic [NUM_EVT*ATTR_W-1:0] evt_attr,
    input  logic                      wr_en,
    input  logic [SEL_W-1:0]          wr_sel,
    input  logic [FN_W-1:0]           wr_data,
    input  logic [SEL_W-1:0]          rd_sel,
    output logic [CTR_W-1:0]          rd_data,
    output logic                      wr_err
);
    func_t            wfn;
    func_t            fn_q  [NUM_CTR];
    logic [CTR_W-1:0] val_q [NUM_CTR];
    logic [NUM_CTR-1:0] addressed;
    logic [NUM_CTR-1:0] accept;
    logic             glob_en;

    assign wfn     = func_t'(wr_data);
    assign glob_en = fn_q[0].glob_en;

    for (genvar i = 0; i < NUM_CTR; i++) begin : g_lane
        assign addressed[i] = wr_en && (int'(wr_sel) == i);
        assign accept[i]    = addressed[i] && code_allowed(i, wfn.code);

        etc_lane #(.CTR_W(CTR_W), .OCC_W(OCC_W), .NUM_EVT(NUM_EVT)) u_lane (
            .clk         (clk),
            .rst_n       (rst_n),
            .priv_kernel (priv_kernel),
            .glob_en     (glob_en),
            .evt_occ     (evt_occ),
            .evt_attr    (evt_attr),
            .fn_we       (accept[i]),
            .fn_wdata    (wfn),
            .fn_q        (fn_q[i]),
            .value       (val_q[i])
        );

        a_r9_keep_old: assert property (@(posedge clk) disable iff (!rst_n)
            (addressed[i] && !accept[i]) |=> $stable(fn_q[i]));
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     wr_err <= 1'b0;
        else if (wr_en) wr_err <= ((accept & addressed) == '0);
    end

    assign rd_data = val_q[rd_sel];

    a_r9_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (accept == '0)) |=> wr_err);
    a_r9_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (accept != '0)) |=> !wr_err);

endmodule

// File: tb/evt_thresh_counter_bench.sv
module evt_thresh_counter_bench;
    localparam int CLK_PERIOD = 10;
    localparam longint MASK40 = (64'd1 << 40) - 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        priv_kernel = 1'b0;
    logic [63:0] evt_occ = '0;
    logic [79:0] evt_attr = '0;
    logic        wr_en = 1'b0;
    logic [0:0]  wr_sel = '0;
    logic [31:0] wr_data = '0;
    logic [0:0]  rd_sel = '0;
    logic [39:0] rd_data;
    logic        wr_err;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    string phase = "R1";

    evt_thresh_counter u_evt_thresh_counter (
        .clk(clk), .rst_n(rst_n), .priv_kernel(priv_kernel),
        .evt_occ(evt_occ), .evt_attr(evt_attr),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .wr_err(wr_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural reference
    logic [31:0] m_fn [2];
    longint      m_cnt [2];
    bit          m_hist [2];
    bit          m_err;
    bit          n_hist [2];

    function automatic void eval_ctr(input logic [31:0] f, input bit en,
                                     output bit act, output int lvl);
        int idx, occ, attr, um, cm;
        bit ok, mode, cond;
        idx  = f[3:0];
        occ  = int'((evt_occ >> (idx*4)) & 64'hF);
        attr = int'((evt_attr >> (idx*5)) & 80'h1F);
        um   = f[15:8];
        cm   = f[31:24];
        ok   = (((um & 15) == 0) || ((um & attr & 15) != 0)) && (((attr & 16) == 0) || ((um & 16) != 0));
        if (!ok) occ = 0;
        mode = en && (priv_kernel ? f[17] : f[16]);
        if (cm == 0) begin
            cond = (occ != 0);
            lvl  = occ;
        end else begin
            cond = f[23] ? (occ <= cm) : (occ >= cm);
            lvl  = cond ? 1 : 0;
        end
        if (!mode) begin
            cond = 0;
            lvl  = 0;
        end
        act = cond;
    endfunction

    function automatic bit allowed(input int sel, input logic [7:0] c);
        if (c == 8'h10 || c == 8'h14 || c == 8'hc1) return sel == 0;
        if (c == 8'h11 || c == 8'h12 || c == 8'h13) return sel == 1;
        return 1;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 2; i++) begin
                m_fn[i] = '0; m_cnt[i] = 0; m_hist[i] = 0;
            end
            m_err = 0;
        end else begin
            for (int i = 0; i < 2; i++) begin
                bit a;
                int l, inc;
                eval_ctr(m_fn[i], m_fn[0][22], a, l);
                inc = m_fn[i][18] ? ((a && !m_hist[i]) ? 1 : 0) : l;
                m_cnt[i] = (m_cnt[i] + inc) & MASK40;
                n_hist[i] = a;
            end
            for (int i = 0; i < 2; i++) m_hist[i] = n_hist[i];
            if (wr_en) begin
                if (allowed(int'(wr_sel), wr_data[7:0])) begin
                    m_fn[wr_sel] = wr_data;
                    m_hist[wr_sel] = 0;
                    m_err = 0;
                end else begin
                    m_err = 1;
                end
            end
        end
    end

    task automatic compare();
        for (int s = 0; s < 2; s++) begin
            rd_sel = s[0:0];
            #1;
            checks++;
            if (rd_data !== m_cnt[s][39:0]) begin
                failures++;
                $display("FAIL %s counter%0d actual=%0h expected=%0h", phase, s, rd_data, m_cnt[s][39:0]);
            end
        end
        checks++;
        if (wr_err !== m_err) begin
            failures++;
            $display("FAIL %s/R9 wr_err actual=%0b expected=%0b", phase, wr_err, m_err);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
        compare();
        wr_en = 1'b0;
    endtask

    task automatic prog(input int sel, input logic [31:0] d);
        wr_en = 1'b1; wr_sel = sel[0:0]; wr_data = d;
        cyc();
    endtask

    task automatic run_rand(input int n, input bit rnd_attr);
        for (int k = 0; k < n; k++) begin
            for (int j = 0; j < 2; j++) evt_occ[j*32 +: 32] = $urandom;
            if (rnd_attr) begin
                for (int j = 0; j < 3; j++) evt_attr[j*32 +: 32] = $urandom;
            end
            cyc();
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        phase = "R1";
        compare();
        run_rand(3, 0);

        phase = "R2/R11";
        priv_kernel = 1'b1;
        prog(0, 32'h00_43_00_05);
        run_rand(10, 0);

        phase = "R3";
        prog(1, 32'h03_03_00_02);
        run_rand(12, 0);

        phase = "R4";
        prog(1, 32'h04_83_00_02);
        run_rand(12, 0);

        phase = "R5";
        prog(0, 32'h00_47_00_05);
        run_rand(16, 0);
        prog(1, 32'h06_07_00_09);
        run_rand(16, 0);

        phase = "R6";
        prog(0, 32'h00_03_00_05);
        run_rand(10, 0);
        prog(1, 32'h00_43_00_02);
        run_rand(6, 0);

        phase = "R7";
        prog(0, 32'h00_41_00_05);
        for (int k = 0; k < 16; k++) begin
            priv_kernel = k[1];
            run_rand(1, 0);
        end
        priv_kernel = 1'b1;

        phase = "R8";
        prog(0, 32'h00_43_05_07);
        prog(1, 32'h00_43_1A_0B);
        run_rand(30, 1);

        phase = "R9";
        prog(0, 32'h00_43_00_12);
        run_rand(4, 0);
        prog(1, 32'h00_43_00_c1);
        run_rand(4, 0);
        prog(1, 32'h00_43_00_13);
        run_rand(2, 0);
        prog(0, 32'h00_43_00_10);
        run_rand(4, 0);

        phase = "R10";
        evt_occ = {16{4'hF}};
        prog(0, 32'h00_47_00_03);
        run_rand(0, 0);
        cyc(); cyc();
        prog(0, 32'h00_47_00_03);
        cyc();
        for (int k = 0; k < 3000; k++) begin
            logic [31:0] d;
            logic [7:0] codes [8] = '{8'h10, 8'h11, 8'h12, 8'h13, 8'h14, 8'hc1, 8'h05, 8'h2a};
            for (int j = 0; j < 2; j++) evt_occ[j*32 +: 32] = $urandom;
            for (int j = 0; j < 3; j++) evt_attr[j*32 +: 32] = $urandom;
            priv_kernel = ($urandom % 4) != 0;
            if (($urandom % 6) == 0) begin
                d = $urandom;
                d[31:24] = 8'($urandom % 12);
                if (($urandom % 4) != 0) d[22] = 1'b1;
                if (($urandom % 3) == 0) d[7:0] = codes[$urandom % 8];
                wr_en = 1'b1; wr_sel = 1'($urandom); wr_data = d;
            end
            cyc();
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule